// File: doc/BRIEF.md
# BT.656 Embedded Sync Inserter

This block is the last stage of a video output formatter. It takes a byte-multiplexed 4:2:2 pixel stream together with a horizontal byte counter and two vertical-timing flags: field and vertical blanking. From these it builds a BT.656 byte stream. Timing reference codes are placed on both sides of the active-video window. Blanking bytes fill the rest of the line. Pixel bytes pass through inside the window on lines that are not vertically blanked.

Changes on the field and blanking flags are not passed to the codes straight away. They are captured only at the first byte of each end-of-active-video code. A change requested anywhere in a line therefore shows up first in the next end code, and the following start code repeats it.

The block also drives a discrete active-video strobe. Its start position can be moved later in the line by a 10-bit crop value. That value is loaded through a two-register pair: the upper bits are staged first, and the new value takes effect only when the low bits are written.

Top module: `bt656_sync_inserter`

## Requirements
- R1: All outputs appear one clock after the `h_cnt` value that produced them. The start code is the byte sequence FF, 00, 00, XY on `h_cnt` = ACT_BEG-4 to ACT_BEG-1. The end code is the same sequence on `h_cnt` = ACT_END to ACT_END+3.
- R2: The XY byte has bit 7 = 1, bit 6 = F, bit 5 = V, bit 4 = H. H is 0 in a start code and 1 in an end code. Bits 3 to 0 are V^H, F^H, F^V and F^V^H.
- R3: The F and V values carried in the codes are sampled from `field_in` and `vblank_in` only when `h_cnt` equals ACT_END. A flag change made at any other point in a line therefore appears first in an end code and never first in a start code.
- R4: For ACT_BEG <= `h_cnt` < ACT_END, the output carries `pix_in` when the held V is 0, and blanking bytes when the held V is 1.
- R5: Every byte that is neither a code byte nor a passed pixel is a blanking byte: 0x80 on even `h_cnt` and 0x10 on odd `h_cnt`.
- R6: A write with `crop_sel` = 0 stages `crop_data` as crop bits [9:2] and leaves the active crop start unchanged. A write with `crop_sel` = 1 sets the crop start to {staged bits, `crop_data[1:0]`}. After reset the crop start is ACT_BEG.
- R7: `avid` is high exactly when crop start <= `h_cnt` < ACT_END. This holds on every line, including vertically blanked ones, and cropping does not change which bytes carry pixel data.
- R8: While `rst` is high, `dout` is 0x10, `avid` is 0, and the held F and V are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel byte clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Multiplexed 4:2:2 pixel byte |
| h_cnt | input | 10 | Horizontal byte position in the line |
| field_in | input | 1 | Requested field flag |
| vblank_in | input | 1 | Requested vertical blanking flag |
| crop_we | input | 1 | Crop register write strobe |
| crop_sel | input | 1 | 0 = stage bits [9:2], 1 = write bits [1:0] and apply |
| crop_data | input | 8 | Crop write data |
| dout | output | 8 | BT.656 byte stream |
| avid | output | 1 | Discrete active-video strobe |

## Verification
The assertions assume that `h_cnt` steps by one every clock and wraps at the line length. They also assume the line is long enough that the end code ends before the next start code begins. The checks that a code byte always follows its code position rely on this ordering. The bench drives `h_cnt` from a loop that counts from 0 to the line length minus 1 without gaps. It moves `field_in` only at chosen positions inside that loop, and issues crop writes between lines, while `h_cnt` is parked in horizontal blanking.

// File: rtl/bt656_pkg.sv
package bt656_pkg;
  localparam logic [7:0] BLANK_CB = 8'h80;
  localparam logic [7:0] BLANK_Y  = 8'h10;

  typedef struct packed {
    logic f;
    logic v;
  } fv_t;

  // Timing reference byte: marker, F, V, H, then four protection bits.
  function automatic logic [7:0] trs_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/bt656_crop_reg.sv
module bt656_crop_reg #(
  parameter int HCW       = 10,
  parameter int RST_START = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [HCW-3:0] wr_data,
  output logic [HCW-1:0] start_o
);
  localparam int UW = HCW - 2;
  localparam logic [HCW-1:0] RST_VAL = HCW'(RST_START);

  logic [UW-1:0]  upper_stage;
  logic [HCW-1:0] start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_stage <= RST_VAL[HCW-1:2];
      start_q     <= RST_VAL;
    end else if (wr_en) begin
      if (!wr_sel) upper_stage <= wr_data;
      else         start_q     <= {upper_stage, wr_data[1:0]};
    end
  end

  assign start_o = start_q;

  AST_UPPER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> $stable(start_q)); // R6
  AST_LOWER_APPLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (start_q[1:0] == $past(wr_data[1:0]))); // R6
endmodule

// File: rtl/bt656_fv_hold.sv
module bt656_fv_hold
  import bt656_pkg::*;
#(
  parameter int HCW     = 10,
  parameter int EAV_POS = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] h_cnt,
  input  logic           field_in,
  input  logic           vblank_in,
  output fv_t            fv_o
);
  localparam logic [HCW-1:0] CAPTURE_AT = HCW'(EAV_POS);

  fv_t fv_q;

  always_ff @(posedge clk) begin
    if (rst)                      fv_q <= '0;
    else if (h_cnt == CAPTURE_AT) fv_q <= '{f: field_in, v: vblank_in};
  end

  assign fv_o = fv_q;

  AST_FV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (h_cnt != CAPTURE_AT) |=> $stable(fv_q)); // R3
endmodule

// File: rtl/bt656_byte_mux.sv
module bt656_byte_mux
  import bt656_pkg::*;
#(
  parameter int HCW     = 10,
  parameter int ACT_BEG = 16,
  parameter int ACT_END = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] h_cnt,
  input  logic [7:0]     pix_in,
  input  fv_t            fv,
  output logic [7:0]     dout
);
  localparam logic [HCW-1:0] SAV0 = HCW'(ACT_BEG - 4);
  localparam logic [HCW-1:0] SAV3 = HCW'(ACT_BEG - 1);
  localparam logic [HCW-1:0] EAV0 = HCW'(ACT_END);
  localparam logic [HCW-1:0] EAV3 = HCW'(ACT_END + 3);
  localparam logic [HCW-1:0] WBEG = HCW'(ACT_BEG);
  localparam logic [HCW-1:0] WEND = HCW'(ACT_END);

  logic [7:0] next_byte;

  always_comb begin
    if (h_cnt == SAV0 || h_cnt == EAV0)
      next_byte = 8'hFF;
    else if (h_cnt == SAV0 + 1 || h_cnt == SAV0 + 2 ||
             h_cnt == EAV0 + 1 || h_cnt == EAV0 + 2)
      next_byte = 8'h00;
    else if (h_cnt == SAV3)
      next_byte = trs_word(fv.f, fv.v, 1'b0);
    else if (h_cnt == EAV3)
      next_byte = trs_word(fv.f, fv.v, 1'b1);
    else if (h_cnt >= WBEG && h_cnt < WEND && !fv.v)
      next_byte = pix_in;
    else
      next_byte = h_cnt[0] ? BLANK_Y : BLANK_CB;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= BLANK_Y;
    else     dout <= next_byte;
  end

  AST_SAV_MARK: assert property (@(posedge clk) disable iff (rst)
    (h_cnt == SAV3) |=> (dout[7] && !dout[4])); // R2
  AST_EAV_MARK: assert property (@(posedge clk) disable iff (rst)
    (h_cnt == EAV3) |=> (dout[7] && dout[4])); // R2
  AST_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    (h_cnt == SAV0 || h_cnt == EAV0) |=> (dout == 8'hFF)); // R1
endmodule

// File: rtl/bt656_sync_inserter.sv
module bt656_sync_inserter
  import bt656_pkg::*;
#(
  parameter int HCW     = 10,
  parameter int ACT_BEG = 16,
  parameter int ACT_END = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [7:0]     pix_in,
  input  logic [HCW-1:0] h_cnt,
  input  logic           field_in,
  input  logic           vblank_in,
  input  logic           crop_we,
  input  logic           crop_sel,
  input  logic [HCW-3:0] crop_data,
  output logic [7:0]     dout,
  output logic           avid
);
  localparam logic [HCW-1:0] WEND = HCW'(ACT_END);

  fv_t            fv;
  logic [HCW-1:0] crop_start;

  bt656_crop_reg #(.HCW(HCW), .RST_START(ACT_BEG)) u_crop (
    .clk(clk), .rst(rst), .wr_en(crop_we), .wr_sel(crop_sel),
    .wr_data(crop_data), .start_o(crop_start)
  );

  bt656_fv_hold #(.HCW(HCW), .EAV_POS(ACT_END)) u_fv (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .field_in(field_in),
    .vblank_in(vblank_in), .fv_o(fv)
  );

  bt656_byte_mux #(.HCW(HCW), .ACT_BEG(ACT_BEG), .ACT_END(ACT_END)) u_mux (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .pix_in(pix_in), .fv(fv), .dout(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) avid <= 1'b0;
    else     avid <= (h_cnt >= crop_start) && (h_cnt < WEND);
  end

  AST_AVID_OFF: assert property (@(posedge clk) disable iff (rst)
    (h_cnt >= WEND) |=> !avid); // R7
  AST_AVID_BEFORE: assert property (@(posedge clk) disable iff (rst)
    (h_cnt < crop_start) |=> !avid); // R7
endmodule

// File: tb/sim_bt656_sync_inserter.sv
module sim_bt656_sync_inserter;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_LEN   = 64;
  localparam int ACT_BEG    = 16;
  localparam int ACT_END    = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pix_in = 8'h00;
  logic [9:0] h_cnt = '0;
  logic       field_in = 1'b0;
  logic       vblank_in = 1'b0;
  logic       crop_we = 1'b0;
  logic       crop_sel = 1'b0;
  logic [7:0] crop_data = 8'h00;
  logic [7:0] dout;
  logic       avid;

  int checks = 0;
  int errors = 0;
  logic [7:0] lbuf [LINE_LEN];
  logic       abuf [LINE_LEN];

  always #(CLK_PERIOD/2) clk = ~clk;

  bt656_sync_inserter #(.HCW(10), .ACT_BEG(ACT_BEG), .ACT_END(ACT_END)) u0 (
    .clk(clk), .rst(rst), .pix_in(pix_in), .h_cnt(h_cnt), .field_in(field_in),
    .vblank_in(vblank_in), .crop_we(crop_we), .crop_sel(crop_sel),
    .crop_data(crop_data), .dout(dout), .avid(avid)
  );

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One full line; field_in flips when h reaches tog_h.
  task automatic drive_line(input logic v, input int tog_h);
    vblank_in = v;
    for (int h = 0; h < LINE_LEN; h++) begin
      if (h == tog_h) field_in = ~field_in;
      h_cnt  = 10'(h);
      pix_in = 8'(8'h20 + h);
      @(posedge clk); #1;
      lbuf[h] = dout;
      abuf[h] = avid;
    end
  endtask

  task automatic crop_write(input logic sel, input logic [7:0] d);
    crop_sel = sel; crop_data = d; crop_we = 1'b1;
    @(posedge clk); #1;
    crop_we = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 dout", dout, 8'h10);
    chk("R8 avid", {7'd0, avid}, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_normal;
    drive_line(1'b0, -1);
    drive_line(1'b0, -1);
    chk("R1 sav0", lbuf[ACT_BEG-4], 8'hFF);
    chk("R1 sav1", lbuf[ACT_BEG-3], 8'h00);
    chk("R1 sav2", lbuf[ACT_BEG-2], 8'h00);
    chk("R2 sav xy", lbuf[ACT_BEG-1], xy(0, 0, 0));
    chk("R1 eav0", lbuf[ACT_END], 8'hFF);
    chk("R1 eav2", lbuf[ACT_END+2], 8'h00);
    chk("R2 eav xy", lbuf[ACT_END+3], xy(0, 0, 1));
    chk("R4 first pixel", lbuf[ACT_BEG], 8'(8'h20 + ACT_BEG));
    chk("R4 last pixel", lbuf[ACT_END-1], 8'(8'h20 + ACT_END - 1));
    chk("R5 blank even", lbuf[0], 8'h80);
    chk("R5 blank odd", lbuf[1], 8'h10);
    chk("R5 blank after eav", lbuf[ACT_END+5], 8'h10);
    chk("R7 avid start", {7'd0, abuf[ACT_BEG]}, 8'h01);
    chk("R7 avid pre", {7'd0, abuf[ACT_BEG-1]}, 8'h00);
    chk("R7 avid end", {7'd0, abuf[ACT_END]}, 8'h00);
  endtask

  task automatic t_vblank;
    drive_line(1'b1, -1);
    chk("R3 sav keeps V=0", lbuf[ACT_BEG-1], xy(0, 0, 0));
    chk("R3 eav shows V=1", lbuf[ACT_END+3], xy(0, 1, 1));
    chk("R4 pixels before capture", lbuf[ACT_BEG+2], 8'(8'h20 + ACT_BEG + 2));
    drive_line(1'b1, -1);
    chk("R2 sav V=1", lbuf[ACT_BEG-1], xy(0, 1, 0));
    chk("R4 blanked even", lbuf[ACT_BEG+4], 8'h80);
    chk("R4 blanked odd", lbuf[ACT_BEG+5], 8'h10);
    chk("R7 avid in vblank", {7'd0, abuf[ACT_BEG+4]}, 8'h01);
    chk("R7 avid off in vblank", {7'd0, abuf[ACT_END+1]}, 8'h00);
    drive_line(1'b0, -1);
    chk("R3 sav still V=1", lbuf[ACT_BEG-1], xy(0, 1, 0));
    chk("R3 eav V=0", lbuf[ACT_END+3], xy(0, 0, 1));
  endtask

  task automatic t_field_toggle;
    drive_line(1'b0, 30);
    chk("R3 sav old field", lbuf[ACT_BEG-1], xy(0, 0, 0));
    chk("R3 eav new field", lbuf[ACT_END+3], xy(1, 0, 1));
    drive_line(1'b0, -1);
    chk("R3 next sav F=1", lbuf[ACT_BEG-1], xy(1, 0, 0));
    drive_line(1'b0, 55);
    chk("R3 eav before toggle", lbuf[ACT_END+3], xy(1, 0, 1));
    drive_line(1'b0, -1);
    chk("R3 sav never first", lbuf[ACT_BEG-1], xy(1, 0, 0));
    chk("R3 eav carries F=0", lbuf[ACT_END+3], xy(0, 0, 1));
  endtask

  task automatic t_crop;
    crop_write(1'b0, 8'h06);
    drive_line(1'b0, -1);
    chk("R6 upper only no effect", {7'd0, abuf[ACT_BEG]}, 8'h01);
    chk("R6 upper only pre", {7'd0, abuf[ACT_BEG-1]}, 8'h00);
    crop_write(1'b1, 8'h01);
    drive_line(1'b0, -1);
    chk("R6 cropped off", {7'd0, abuf[24]}, 8'h00);
    chk("R6 cropped on", {7'd0, abuf[25]}, 8'h01);
    chk("R7 cropped last", {7'd0, abuf[ACT_END-1]}, 8'h01);
    chk("R7 cropped end", {7'd0, abuf[ACT_END]}, 8'h00);
    chk("R7 data unaffected", lbuf[ACT_BEG], 8'(8'h20 + ACT_BEG));
  endtask

  initial begin
    t_reset;
    t_normal;
    t_vblank;
    t_field_toggle;
    t_crop;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule